// File: doc/BRIEF.md
# Packed Float24 Vector Loader

This block turns a stream of 32-bit data-port writes into four-component vectors of 24-bit floats and hands each finished vector to an indexed vector memory through a write port. Software first loads a destination index. It then pushes words one at a time. A staging buffer holds the words until a whole vector has arrived. The block then unpacks or converts the words, issues one memory write, and moves the index on by one, so a run of vectors fills consecutive slots.

There are two encodings, chosen by a mode input. In packed mode, three words carry four 24-bit values laid end to end. In single-precision mode, four words each carry one IEEE single, and each single is narrowed to the 24-bit layout. In both modes the first word received lands in the highest component. An index above the last valid slot blocks the write and raises an error pulse.

A 24-bit float is laid out as bit 23 for the sign, bits 22:16 for a 7-bit exponent with bias 63, and bits 15:0 for the mantissa. A vector on the write port carries component c in bits [24c+23:24c], with x as component 0, y as 1, z as 2 and w as 3.

Top module: `f24_vec_loader`

## Requirements
- R1: With `mode_f32` low, a vector commits on the third accepted word, and the first and second words cause no memory write.
- R2: With `mode_f32` high, a vector commits on the fourth accepted word, and the first three cause no memory write.
- R3: In packed mode, with words a, b, c in arrival order, the components are: w = a[31:8], z = {a[7:0], b[31:16]}, y = {b[15:0], c[31:24]}, x = c[23:0].
- R4: In single-precision mode, the word that arrives k-th (k = 0..3) is converted and placed in component 3-k.
- R5: A single with biased exponent e in the range 65..190 converts to the same sign, exponent e-64, and mantissa bits [22:7] of the single.
- R6: A single with exponent field 64 or below, including zero and denormals, converts to its sign bit followed by 23 zero bits.
- R7: A single with exponent field 191 or above, including infinities and NaNs, converts to its sign bit, exponent 0x7F and a zero mantissa.
- R8: Each commit writes to the current index on `mem_addr`, and `cur_index` then reads one higher.
- R9: An index write loads `cur_index` and discards any partly collected vector. A data word presented in the same cycle is dropped.
- R10: A commit while the index is above MAX_INDEX (95 by default) issues no memory write. It raises `range_err` for one cycle, leaves the index unchanged and still clears the staging buffer.
- R11: `mem_we` or `range_err` rises in the cycle after the final word is accepted and lasts one cycle. The data port accepts a word in every cycle, including the cycle after a commit.
- R12: After reset, the index is 0, the staging buffer is empty, and neither `mem_we` nor `range_err` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr_en | input | 1 | Load destination index and clear staging |
| idx_wr_data | input | IDX_W | New destination index |
| word_wr_en | input | 1 | Data word valid |
| word_wr_data | input | 32 | Data word |
| mode_f32 | input | 1 | 1: four single-precision words per vector, 0: three packed words |
| mem_we | output | 1 | Vector memory write strobe |
| mem_addr | output | IDX_W | Vector memory write address |
| mem_wdata | output | 96 | Four 24-bit components, x in the low bits |
| range_err | output | 1 | Pulse: commit attempted with index out of range |
| cur_index | output | IDX_W | Current destination index |

## Verification
The assertions assume that `idx_wr_en` and `word_wr_en` are held low while reset is asserted. They also assume that `mode_f32` only changes between vectors, never partway through one. The stimulus changes the mode only after a commit or right after an index write, and it drives every input at the falling clock edge, so both assumptions hold. The single-precision sweep walks all 256 exponent codes with alternating signs. The packed and error cases cover both index boundaries and the concurrent index-and-data write.

// File: rtl/f24_vec_pkg.sv
package f24_vec_pkg;
  localparam int F24_W        = 24;
  localparam int F32_W        = 32;
  localparam int NUM_COMP     = 4;
  localparam int PACKED_WORDS = 3;
  localparam int F32_WORDS    = 4;
  localparam int MAX_WORDS    = (F32_WORDS > PACKED_WORDS) ? F32_WORDS : PACKED_WORDS;
  localparam int VEC_W        = NUM_COMP * F24_W;

  typedef logic [F24_W-1:0] f24_t;
  typedef logic [F32_W-1:0] word_t;
endpackage

// File: rtl/f24_from_f32.sv
module f24_from_f32
  import f24_vec_pkg::*;
#(
  parameter int EXP_W = 7,
  parameter int MAN_W = 16
) (
  input  word_t f32_in,
  output f24_t  f24_out
);
  localparam int BIAS_NARROW = (1 << (EXP_W - 1)) - 1;
  localparam int REBIAS      = 127 - BIAS_NARROW;
  localparam int EXP_TOP     = (1 << EXP_W) - 1;
  localparam int OVF_LIMIT   = REBIAS + EXP_TOP;

  logic       sgn;
  logic [7:0] e_wide;
  logic [7:0] e_adj;

  always_comb begin
    sgn    = f32_in[31];
    e_wide = f32_in[30:23];
    e_adj  = e_wide - 8'(REBIAS);
    if (e_wide <= 8'(REBIAS)) begin
      f24_out = {sgn, {(F24_W-1){1'b0}}};
    end else if (e_wide >= 8'(OVF_LIMIT)) begin
      f24_out = {sgn, EXP_W'(EXP_TOP), {MAN_W{1'b0}}};
    end else begin
      f24_out = {sgn, e_adj[EXP_W-1:0], f32_in[22 -: MAN_W]};
    end
  end
endmodule

// File: rtl/f24_word_stager.sv
module f24_word_stager
  import f24_vec_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clear,
  input  logic                      wr_en,
  input  word_t                     wr_data,
  input  logic                      mode_f32,
  output logic                      fire,
  output logic [MAX_WORDS-1:0][F32_W-1:0] words
);
  localparam int CNT_W = $clog2(MAX_WORDS);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  word_t            stage [MAX_WORDS];
  logic             take;

  assign last = mode_f32 ? CNT_W'(F32_WORDS - 1) : CNT_W'(PACKED_WORDS - 1);
  assign take = wr_en && !clear;
  assign fire = take && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (take) begin
      cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      stage[cnt] <= wr_data;
    end
  end

  for (genvar i = 0; i < MAX_WORDS; i++) begin : g_assemble
    assign words[i] = (take && cnt == CNT_W'(i)) ? wr_data : stage[i];
  end
endmodule

// File: rtl/f24_vec_unpack.sv
module f24_vec_unpack
  import f24_vec_pkg::*;
#(
  parameter int EXP_W = 7,
  parameter int MAN_W = 16
) (
  input  logic [MAX_WORDS-1:0][F32_W-1:0] words,
  input  logic                            mode_f32,
  output logic [NUM_COMP-1:0][F24_W-1:0]  vec
);
  localparam int CAT_W = PACKED_WORDS * F32_W;

  logic [CAT_W-1:0] cat;

  // First word at the top: component 3 takes its upper 24 bits.
  assign cat = {words[0], words[1], words[2]};

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    f24_t conv;
    f24_from_f32 #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_conv (
      .f32_in  (words[NUM_COMP-1-c]),
      .f24_out (conv)
    );
    assign vec[c] = mode_f32 ? conv : cat[c*F24_W +: F24_W];
  end
endmodule

// File: rtl/f24_vec_loader.sv
module f24_vec_loader
  import f24_vec_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int MAX_INDEX = 95,
  parameter int EXP_W     = 7,
  parameter int MAN_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idx_wr_en,
  input  logic [IDX_W-1:0] idx_wr_data,
  input  logic             word_wr_en,
  input  logic [31:0]      word_wr_data,
  input  logic             mode_f32,
  output logic             mem_we,
  output logic [IDX_W-1:0] mem_addr,
  output logic [95:0]      mem_wdata,
  output logic             range_err,
  output logic [IDX_W-1:0] cur_index
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_INDEX);

  logic                            fire;
  logic [MAX_WORDS-1:0][F32_W-1:0] words;
  logic [NUM_COMP-1:0][F24_W-1:0]  vec;
  logic [IDX_W-1:0]                idx_q;
  logic                            in_range;

  f24_word_stager u_stage (
    .clk      (clk),
    .rst      (rst),
    .clear    (idx_wr_en),
    .wr_en    (word_wr_en),
    .wr_data  (word_wr_data),
    .mode_f32 (mode_f32),
    .fire     (fire),
    .words    (words)
  );

  f24_vec_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .words    (words),
    .mode_f32 (mode_f32),
    .vec      (vec)
  );

  assign in_range = (idx_q <= LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      range_err <= 1'b0;
    end else begin
      mem_we    <= 1'b0;
      range_err <= 1'b0;
      if (idx_wr_en) begin
        idx_q <= idx_wr_data;
      end else if (fire) begin
        if (in_range) begin
          mem_we    <= 1'b1;
          mem_addr  <= idx_q;
          mem_wdata <= vec;
          idx_q     <= idx_q + 1'b1;
        end else begin
          range_err <= 1'b1;
        end
      end
    end
  end

  assign cur_index = idx_q;
endmodule

// File: rtl/f24_vec_loader_chk.sv
module f24_vec_loader_chk #(
  parameter int IDX_W     = 7,
  parameter int MAX_INDEX = 95
) (
  input logic             clk,
  input logic             rst,
  input logic             idx_wr_en,
  input logic [IDX_W-1:0] idx_wr_data,
  input logic             word_wr_en,
  input logic             mem_we,
  input logic [IDX_W-1:0] mem_addr,
  input logic             range_err,
  input logic [IDX_W-1:0] cur_index
);
  assert_commit_follows_word_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_we || range_err) |-> $past(word_wr_en && !idx_wr_en));

  assert_single_cycle_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_write_in_range_R10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (int'(mem_addr) <= MAX_INDEX));

  assert_write_or_error_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && range_err));

  assert_index_held_on_error_R10: assert property (@(posedge clk) disable iff (rst)
    range_err |-> $stable(cur_index));

  assert_index_advances_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (cur_index == mem_addr + 1'b1));

  assert_index_load_R9: assert property (@(posedge clk) disable iff (rst)
    $past(idx_wr_en) |-> (cur_index == $past(idx_wr_data) && !mem_we && !range_err));
endmodule

bind f24_vec_loader f24_vec_loader_chk #(.IDX_W(IDX_W), .MAX_INDEX(MAX_INDEX)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .idx_wr_en   (idx_wr_en),
  .idx_wr_data (idx_wr_data),
  .word_wr_en  (word_wr_en),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .range_err   (range_err),
  .cur_index   (cur_index)
);

// File: tb/f24_vec_loader_bench.sv
module f24_vec_loader_bench;
  localparam int IDX_W     = 7;
  localparam int MAX_INDEX = 95;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             idx_wr_en = 1'b0;
  logic [IDX_W-1:0] idx_wr_data = '0;
  logic             word_wr_en = 1'b0;
  logic [31:0]      word_wr_data = '0;
  logic             mode_f32 = 1'b0;
  logic             mem_we;
  logic [IDX_W-1:0] mem_addr;
  logic [95:0]      mem_wdata;
  logic             range_err;
  logic [IDX_W-1:0] cur_index;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  f24_vec_loader #(.IDX_W(IDX_W), .MAX_INDEX(MAX_INDEX)) u_f24_vec_loader (
    .clk(clk), .rst(rst), .idx_wr_en(idx_wr_en), .idx_wr_data(idx_wr_data),
    .word_wr_en(word_wr_en), .word_wr_data(word_wr_data), .mode_f32(mode_f32),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .range_err(range_err), .cur_index(cur_index)
  );

  function automatic logic [31:0] mix(int k);
    return 32'(k) * 32'h9E3779B1 + 32'h7F4A7C15;
  endfunction

  function automatic logic [23:0] ref_f24(logic [31:0] b);
    int s, e, m, ne;
    s  = int'(b >> 31);
    e  = int'((b >> 23) & 32'hFF);
    m  = int'(b & 32'h7FFFFF);
    ne = e - 127 + 63;
    if (ne <= 0)   return 24'(s * 8388608);
    if (ne >= 127) return 24'(s * 8388608 + 127 * 65536);
    return 24'(s * 8388608 + ne * 65536 + m / 128);
  endfunction

  function automatic logic [95:0] ref_packed(logic [31:0] a, logic [31:0] b, logic [31:0] c);
    logic [31:0] w, z, y, x;
    w = a >> 8;
    z = ((a & 32'hFF) << 16) | (b >> 16);
    y = ((b & 32'hFFFF) << 8) | (c >> 24);
    x = c & 32'hFFFFFF;
    return {w[23:0], z[23:0], y[23:0], x[23:0]};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic set_index(logic [IDX_W-1:0] v);
    @(negedge clk); idx_wr_en = 1'b1; idx_wr_data = v;
    @(negedge clk); idx_wr_en = 1'b0;
  endtask

  task automatic put_word(logic [31:0] v);
    @(negedge clk); word_wr_en = 1'b1; word_wr_data = v;
    @(negedge clk); word_wr_en = 1'b0;
  endtask

  task automatic send_packed(logic [31:0] a, logic [31:0] b, logic [31:0] c, logic [IDX_W-1:0] at);
    logic [95:0] exp;
    exp = ref_packed(a, b, c);
    put_word(a);
    check(!mem_we, "R1", "no write after word 1", 96'(mem_we), 96'(0));
    put_word(b);
    check(!mem_we, "R1", "no write after word 2", 96'(mem_we), 96'(0));
    put_word(c);
    check(mem_we, "R1", "write after word 3", 96'(mem_we), 96'(1));
    check(mem_addr == at, "R8", "write address", 96'(mem_addr), 96'(at));
    check(mem_wdata == exp, "R3", "packed unpack", mem_wdata, exp);
    check(cur_index == at + 1'b1, "R8", "index advanced", 96'(cur_index), 96'(at + 1'b1));
    @(negedge clk);
    check(!mem_we, "R11", "strobe is one cycle", 96'(mem_we), 96'(0));
  endtask

  function automatic string cls_tag(logic [31:0] b);
    int e;
    e = int'((b >> 23) & 32'hFF);
    if (e <= 64)  return "R6";
    if (e >= 191) return "R7";
    return "R5";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] ww [4];
    logic [95:0] exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(!mem_we, "R12", "mem_we after reset", 96'(mem_we), 96'(0));
    check(!range_err, "R12", "range_err after reset", 96'(range_err), 96'(0));
    check(cur_index == '0, "R12", "index after reset", 96'(cur_index), 96'(0));
    // R12 empty stager: first vector commits at index 0 after exactly three words
    send_packed(mix(1), mix(2), mix(3), 0);

    // Packed sweep (R1, R3, R8)
    set_index(1);
    for (int v = 0; v < 12; v++) begin
      send_packed(mix(10 + 3*v), mix(11 + 3*v), ~mix(12 + 3*v), IDX_W'(1 + v));
    end
    send_packed(32'hFFFFFFFF, 32'h00000000, 32'hA5A5A5A5, 13);
    send_packed(32'h00000000, 32'hFFFFFFFF, 32'h5A5A5A5A, 14);

    // Single-precision exponent sweep (R4..R7)
    mode_f32 = 1'b1;
    set_index(10);
    for (int v = 0; v < 64; v++) begin
      for (int i = 0; i < 4; i++) begin
        ww[i] = {1'(v ^ i), 8'(4*v + i), mix(100 + 4*v + i)[22:0]};
      end
      for (int i = 0; i < 4; i++) begin
        put_word(ww[i]);
        if (i < 3) check(!mem_we, "R2", "no write before word 4", 96'(mem_we), 96'(0));
      end
      exp = {ref_f24(ww[0]), ref_f24(ww[1]), ref_f24(ww[2]), ref_f24(ww[3])};
      check(mem_we && mem_addr == IDX_W'(10 + v), "R2", "write after word 4", 96'(mem_addr), 96'(10 + v));
      check(mem_wdata == exp, "R4", "reversed component order", mem_wdata, exp);
      for (int c = 0; c < 4; c++) begin
        check(mem_wdata[24*c +: 24] == ref_f24(ww[3-c]), cls_tag(ww[3-c]), "component conversion",
              96'(mem_wdata[24*c +: 24]), 96'(ref_f24(ww[3-c])));
      end
    end

    // Back-to-back words (R11)
    set_index(40);
    for (int k = 0; k <= 8; k++) begin
      @(negedge clk);
      if (k == 4 || k == 8) begin
        exp = {ref_f24(mix(200 + k - 4)), ref_f24(mix(201 + k - 4)),
               ref_f24(mix(202 + k - 4)), ref_f24(mix(203 + k - 4))};
        check(mem_we && mem_addr == IDX_W'(40 + k/4 - 1), "R11", "burst commit",
              96'(mem_addr), 96'(40 + k/4 - 1));
        check(mem_wdata == exp, "R11", "burst data", mem_wdata, exp);
      end else begin
        check(!mem_we, "R11", "burst no write", 96'(mem_we), 96'(0));
      end
      word_wr_en   = (k < 8);
      word_wr_data = mix(200 + k);
    end
    @(negedge clk);

    // Index write discards partial vector (R9)
    mode_f32 = 1'b0;
    set_index(5);
    put_word(mix(300));
    put_word(mix(301));
    set_index(20);
    check(cur_index == 7'd20, "R9", "index loaded", 96'(cur_index), 96'(20));
    send_packed(mix(302), mix(303), mix(304), 20);
    // Simultaneous index and data write: data word dropped
    @(negedge clk); idx_wr_en = 1'b1; idx_wr_data = 30; word_wr_en = 1'b1; word_wr_data = mix(305);
    @(negedge clk); idx_wr_en = 1'b0; word_wr_en = 1'b0;
    check(cur_index == 7'd30 && !mem_we, "R9", "concurrent write drops word", 96'(cur_index), 96'(30));
    send_packed(mix(306), mix(307), mix(308), 30);

    // Range boundary (R10)
    set_index(7'(MAX_INDEX));
    send_packed(mix(400), mix(401), mix(402), 7'(MAX_INDEX));
    for (int rep = 0; rep < 2; rep++) begin
      put_word(mix(410 + rep));
      check(!range_err && !mem_we, "R10", "no error on word 1", 96'(range_err), 96'(0));
      put_word(mix(420 + rep));
      check(!range_err && !mem_we, "R10", "no error on word 2", 96'(range_err), 96'(0));
      put_word(mix(430 + rep));
      check(range_err, "R10", "error on commit", 96'(range_err), 96'(1));
      check(!mem_we, "R10", "write suppressed", 96'(mem_we), 96'(0));
      check(cur_index == 7'(MAX_INDEX + 1), "R10", "index held", 96'(cur_index), 96'(MAX_INDEX + 1));
      @(negedge clk);
      check(!range_err, "R10", "error is a pulse", 96'(range_err), 96'(0));
    end
    set_index(7'd127);
    put_word(mix(500)); put_word(mix(501)); put_word(mix(502));
    check(range_err && !mem_we && cur_index == 7'd127, "R10", "top index rejected",
          96'(cur_index), 96'(127));
    // Buffer cleared after error: next vector at a valid index commits on third word
    set_index(3);
    send_packed(mix(503), mix(504), mix(505), 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule